// File: doc/BRIEF.md
# GPIO Port with Masked Output Writes

This block is a 32-pin general-purpose I/O port behind a small memory-mapped register bank. A 32-bit bus with single-cycle write and read strobes reaches it. For each pin the block drives an output-enable bit and an output-data bit toward the pad ring. It also samples a pad input vector through a two-flop synchronizer.

Software changes pin direction through two registers. Writing ones to the first turns the chosen pins into outputs. Writing ones to the second turns them back into inputs. Zero bits in either write leave their pins alone.

Output levels are written through two half-word registers, one for pins 0-15 and one for pins 16-31. Each write carries a 16-bit mask in its upper half and 16 new levels in its lower half. Only the pins whose mask bit is set change. Because of this, any single pin's level or direction can be changed atomically, with no read-modify-write. The output-data latch always holds its value, whatever the direction. Software can therefore preload a level and only then enable the driver.

Top module: `gpio_mask_port`

## Requirements
- R1: While rst_n is low and after its release, pad_oe is all zeros (every pin is an input), pad_out is all zeros and rdata is zero.
- R2: A write to offset 0x00 sets each pad_oe bit whose wdata bit is 1. Bits written as 0 keep their previous direction.
- R3: A write to offset 0x04 clears each pad_oe bit whose wdata bit is 1. Bits written as 0 keep their previous direction.
- R4: A write to offset 0x08 loads pad_out[i] with wdata[i] for each i in 0..15 where wdata[16+i] is 1. Every other pin of the low half keeps its level, and pins 16-31 are untouched.
- R5: A write to offset 0x0C loads pad_out[16+i] with wdata[i] for each i in 0..15 where wdata[16+i] is 1. Every other pin keeps its level.
- R6: The output-data latch is independent of direction. A level written while the pin is an input appears on pad_out immediately and is kept when the pin later becomes an output.
- R7: A read of offset 0x10 returns pad_in through a two-flop synchronizer. A pad change set up before clock edge k is first returned by a read strobe sampled at edge k+2. Reads sampled at edges k and k+1 still return the old level.
- R8: Read data appears on rdata one clock after the rd_en strobe and holds until the next read. Offsets 0x00 and 0x04 return pad_oe. Offset 0x08 returns pad_out[15:0] in bits 15:0, and 0x0C returns pad_out[31:16] in bits 15:0. Bits 31:16 read as zero for both output offsets.
- R9: Writes to offset 0x10 or to any unmapped offset change neither pad_oe nor pad_out. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Input levels from the pads |
| pad_oe | output | 32 | Output enable per pin, 1 = drive |
| pad_out | output | 32 | Output level per pin |

## Verification
The hardest case to reach is the isolation that a masked low-half write has to provide. The write must leave the unmasked low pins and all sixteen high pins untouched, and a wrong implementation can still pass if the latch already holds the written values.

To rule that out, the stimulus first loads distinct, non-trivial patterns into both halves. It then issues low-half writes whose data bits are all ones but whose masks cover only a few pins, or no pins at all, and reads both halves back. The input synchronizer latency is pinned down by changing pad_in in the same cycle as a read strobe and issuing two further back-to-back reads, so the exact edge at which the new level appears is checked.

// File: rtl/gpio_pkg.sv
// Package: shared widths and register offsets of the GPIO port.
// Assumes a byte-addressed bus with word-aligned offsets.
package gpio_pkg;
    localparam int HALF_W = 16;
    localparam int PINS   = 2 * HALF_W;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DIR_SET = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR_CLR = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_OUT_LO  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT_HI  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_PIN_IN  = 5'h10;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_DSET, SEL_DCLR, SEL_OLO, SEL_OHI, SEL_PIN
    } reg_sel_e;

    // Decode a byte offset into a register select.
    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_DIR_SET: return SEL_DSET;
            OFS_DIR_CLR: return SEL_DCLR;
            OFS_OUT_LO:  return SEL_OLO;
            OFS_OUT_HI:  return SEL_OHI;
            OFS_PIN_IN:  return SEL_PIN;
            default:     return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/gpio_dir_reg.sv
// Module: direction vector with separate set and clear strobes.
// Assumes set and clear are never asserted in the same cycle (one bus write per cycle).
module gpio_dir_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] dir
);
    // Update the direction: set ones, clear ones, keep the rest.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir <= '0;
        else if (set_en) dir <= dir | bits;
        else if (clr_en) dir <= dir & ~bits;
    end

    // R2
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (((dir & $past(bits)) == $past(bits)) &&
                    ((dir & ~$past(bits)) == ($past(dir) & ~$past(bits)))));

    // R3
    dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (((dir & $past(bits)) == '0) &&
                    ((dir & ~$past(bits)) == ($past(dir) & ~$past(bits)))));
endmodule

// File: rtl/gpio_out_half.sv
// Module: one half-word output-data latch updated through a bit mask.
// Assumes mask and val arrive together in one write; the latch ignores direction.
module gpio_out_half #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] val,
    output logic [W-1:0] q
);
    // Load the masked bits, keep the unmasked ones.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= (q & ~mask) | (val & mask);
    end

    // R4
    out_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((q ^ $past(q)) & ~$past(mask)) == '0);

    // R5
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));
endmodule

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for the pad input vector.
// Assumes each pad bit is independent; no bus coherence across bits.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the pad levels through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

    // R7
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> q == $past(meta));
endmodule

// File: rtl/gpio_mask_port.sv
// Module: 32-pin GPIO port top: register decode, direction, output halves, input sync.
// Assumes single-cycle strobes and at most one access per cycle.
module gpio_mask_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    output logic [PINS-1:0]   rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out
);
    reg_sel_e           sel;
    logic [HALF_W-1:0]  half_q [2];
    logic [1:0]         half_wr;
    logic [PINS-1:0]    pin_lvl;
    logic [PINS-1:0]    rd_mux;

    // Decode the current offset.
    always_comb sel = decode(addr);

    gpio_dir_reg #(.W(PINS)) dir_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_en && sel == SEL_DSET),
        .clr_en (wr_en && sel == SEL_DCLR),
        .bits   (wdata),
        .dir    (pad_oe)
    );

    // Select which output half a write targets.
    always_comb begin
        half_wr[0] = wr_en && sel == SEL_OLO;
        half_wr[1] = wr_en && sel == SEL_OHI;
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        gpio_out_half #(.W(HALF_W)) half_i (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (half_wr[h]),
            .mask  (wdata[PINS-1:HALF_W]),
            .val   (wdata[HALF_W-1:0]),
            .q     (half_q[h])
        );
        assign pad_out[h*HALF_W +: HALF_W] = half_q[h];
    end

    gpio_in_sync #(.W(PINS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_lvl)
    );

    // Pick the read value for the current offset.
    always_comb begin
        unique case (sel)
            SEL_DSET, SEL_DCLR: rd_mux = pad_oe;
            SEL_OLO:            rd_mux = {{HALF_W{1'b0}}, half_q[0]};
            SEL_OHI:            rd_mux = {{HALF_W{1'b0}}, half_q[1]};
            SEL_PIN:            rd_mux = pin_lvl;
            default:            rd_mux = '0;
        endcase
    end

    // Register read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_NONE || sel == SEL_PIN)) |=>
            ($stable(pad_oe) && $stable(pad_out)));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && $past(rst_n)) |=> $stable(rdata));
endmodule

// File: tb/gpio_mask_port_tb_top.sv
module gpio_mask_port_tb_top;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [4:0]  addr;
    logic [31:0] wdata, rdata, pad_in, pad_oe, pad_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    gpio_mask_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe),
        .pad_out(pad_out)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [31:0] ex;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'h00, 32'h0000_00F1, 5'h00, 32'h0000_00F1, 4'd2},  // R2 set
        '{5'h00, 32'h8000_0000, 5'h00, 32'h8000_00F1, 4'd2},  // R2 zeros keep
        '{5'h04, 32'h0000_0011, 5'h04, 32'h8000_00E0, 4'd3},  // R3 clear
        '{5'h08, 32'h00FF_1234, 5'h08, 32'h0000_0034, 4'd4},  // R4 masked low
        '{5'h0C, 32'hFFFF_ABCD, 5'h0C, 32'h0000_ABCD, 4'd5},  // R5 high
        '{5'h08, 32'h0F00_FFFF, 5'h08, 32'h0000_0F34, 4'd4},  // R4 partial mask
        '{5'h08, 32'h0F00_FFFF, 5'h0C, 32'h0000_ABCD, 4'd4},  // R4 high untouched
        '{5'h08, 32'h0000_FFFF, 5'h08, 32'h0000_0F34, 4'd4},  // R4 empty mask
        '{5'h10, 32'hFFFF_FFFF, 5'h08, 32'h0000_0F34, 4'd9},  // R9 input offset
        '{5'h1C, 32'hFFFF_FFFF, 5'h00, 32'h8000_00E0, 4'd9}   // R9 unmapped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        pad_in = 32'h0000_0000;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pad_oe in reset", pad_oe, 32'h0);
        check("R1 pad_out in reset", pad_out, 32'h0);
        check("R1 rdata in reset", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad_oe after release", pad_oe, 32'h0);
        bus_rd(5'h08, rv);
        check("R1 out latch after reset", rv, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_wr(VECS[i].wa, VECS[i].wd);
            bus_rd(VECS[i].ra, rv);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), rv, VECS[i].ex);
        end
        check("R2 pad_oe port", pad_oe, 32'h8000_00E0);
        check("R5 pad_out port", pad_out, 32'hABCD_0F34);

        // R6 preload while input, then enable
        bus_wr(5'h0C, 32'h0010_0010);
        check("R6 preload visible while input", pad_out, 32'hABDD_0F34);
        check("R6 pin still input", pad_oe & 32'h0010_0000, 32'h0);
        bus_wr(5'h00, 32'h0010_0000);
        check("R6 pin now output", pad_oe, 32'h8010_00E0);
        check("R6 level kept", pad_out, 32'hABDD_0F34);

        // R8 upper bits of output readback read zero, dir via clear offset
        bus_rd(5'h0C, rv);
        check("R8 high half readback", rv, 32'h0000_ABDD);
        bus_rd(5'h04, rv);
        check("R8 dir via clear offset", rv, 32'h8010_00E0);

        // R9 unmapped read
        bus_rd(5'h14, rv);
        check("R9 unmapped read", rv, 32'h0);

        // R7 synchronizer latency
        pad_in = 32'h1234_5678;
        repeat (4) @(negedge clk);
        bus_rd(5'h10, rv);
        check("R7 settled input", rv, 32'h1234_5678);
        @(negedge clk);
        pad_in = 32'hCAFE_F00D; rd_en = 1'b1; addr = 5'h10;
        @(negedge clk);
        check("R7 read at edge k", rdata, 32'h1234_5678);
        @(negedge clk);
        check("R7 read at edge k+1", rdata, 32'h1234_5678);
        @(negedge clk);
        rd_en = 1'b0;
        check("R7 read at edge k+2", rdata, 32'hCAFE_F00D);

        // R8 rdata holds without strobe
        repeat (3) @(negedge clk);
        check("R8 rdata held", rdata, 32'hCAFE_F00D);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule